// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of a pipeline that issues instructions in program order and lets them complete out of order on several functional units. For each decoded instruction offered to it, it decides whether the instruction may enter its target unit. Once the instruction has entered, it decides in which cycle the unit may fetch its operands and in which cycle the unit may write its result back. The arithmetic, the register file contents and memory sit outside; the units appear here only as one completion pulse each.

Three tables hold the state. A register result table records which unit will produce each register. A per-unit entry records the operation, the destination, both sources, the producing unit of each source and a ready flag per source. A per-unit stage machine records how far the instruction has progressed. The stage machine has four named states. `ST_WRITTEN` (code 3) means the unit is free. `ST_ISSUED` (code 0) means it is waiting for its operands. `ST_READ` (code 1) means it is executing. `ST_EXEC_DONE` (code 2) means it is waiting to write back. The transitions are `ST_WRITTEN`→`ST_ISSUED` on issue, `ST_ISSUED`→`ST_READ` on an operand-read grant, `ST_READ`→`ST_EXEC_DONE` on the unit's completion pulse, and `ST_EXEC_DONE`→`ST_WRITTEN` on a write-back grant.

Issue is held back on a busy unit (structural hazard) or a pending destination (WAW). Operand read waits until both sources are ready (RAW). Write-back waits while any other unit has not yet read the old value of the destination (WAR). All decisions are combinational from registered state, and every table changes at the clock edge that follows.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset every unit is free, no register is pending, `rd_grant` and `wb_grant` are all zero, and an instruction offered to any unit is not stalled.
- R2: `iss_stall` is high in a cycle where `iss_valid` is high and the unit selected by `iss_unit` still holds an instruction that has not written back.
- R3: `iss_stall` is high in a cycle where `iss_valid` is high and `iss_dst` is the destination of an instruction that has not written back.
- R4: An instruction presented while `iss_stall` is high leaves no trace: its unit and its destination are later accepted as free.
- R5: A source whose bypass flag (`iss_src1_imm` or `iss_src2_imm`) is set, or whose register is not pending, is ready at issue. An instruction with both sources ready gets its operand-read grant in the cycle after issue.
- R6: An operand-read grant is raised for exactly one cycle per issued instruction. Bit u of `rd_grant` belongs to unit u.
- R7: A `fu_done` pulse is accepted only from a unit that has read its operands; pulses in any other state have no effect.
- R8: A unit that has completed is refused write-back while another unit, holding a register source equal to its destination, is ready on that source but has not yet read it. A source still waiting on a producer does not hold write-back.
- R9: At most one bit of `wb_grant` is high in a cycle; among eligible units the lowest index wins and the others wait.
- R10: Every unit waiting on the unit being written back has that source marked ready. If its other source is ready, its operand-read grant follows in the next cycle.
- R11: An instruction issued in the same cycle as the write-back of the producer of one of its sources treats that source as ready.
- R12: Write-back frees the unit and the destination register, so in the next cycle a new instruction may issue to that unit and that destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | A decoded instruction is offered |
| iss_op | input | OP_W | Operation code, passed on to the unit |
| iss_unit | input | clog2(N_UNITS) | Target functional unit index |
| iss_dst | input | clog2(N_REGS) | Destination register |
| iss_src1 | input | clog2(N_REGS) | First source register |
| iss_src2 | input | clog2(N_REGS) | Second source register |
| iss_src1_imm | input | 1 | First source needs no tracking (immediate or integer register) |
| iss_src2_imm | input | 1 | Second source needs no tracking |
| fu_done | input | N_UNITS | Per-unit execution complete pulse |
| iss_stall | output | 1 | The offered instruction is not accepted this cycle |
| rd_grant | output | N_UNITS | Per-unit operand-read permission |
| wb_grant | output | N_UNITS | Per-unit write-back permission, at most one high |
| unit_op | output | N_UNITS x OP_W | Operation held by each unit |

## Verification
Issue and write-back can fall in the same cycle. The bench provokes this by offering an instruction whose first source is produced by a unit that is granted write-back in that very cycle. It then judges that the new instruction is not left waiting on a broadcast it has already missed: its read grant must appear in the next cycle, together with that of an older unit woken by the same write-back. The other collision is a completed unit whose write-back coincides with a reader that has not consumed the same register. The bench expects the write-back grant to stay low in that cycle and to rise in the cycle after the reader's grant.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Stage of the instruction held by one functional unit.
    // ST_WRITTEN doubles as the free state of the unit.
    typedef enum logic [1:0] {
        ST_ISSUED    = 2'd0,
        ST_READ      = 2'd1,
        ST_EXEC_DONE = 2'd2,
        ST_WRITTEN   = 2'd3
    } stage_e;

endpackage

// File: rtl/sb_unit_entry.sv
module sb_unit_entry
    import sb_pkg::*;
#(
    parameter int OP_W  = 4,
    parameter int REG_W = 4,
    parameter int UID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_en,
    input  logic [OP_W-1:0]  iss_op,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [REG_W-1:0] iss_src1,
    input  logic [REG_W-1:0] iss_src2,
    input  logic             iss_use1,
    input  logic             iss_use2,
    input  logic             iss_wait1,
    input  logic             iss_wait2,
    input  logic [UID_W-1:0] iss_q1,
    input  logic [UID_W-1:0] iss_q2,
    input  logic             wb_valid,
    input  logic [UID_W-1:0] wb_tag,
    input  logic             wb_take,
    input  logic             fu_done,
    output logic             busy,
    output logic             rd_req,
    output logic             wb_req,
    output logic [OP_W-1:0]  op,
    output logic [REG_W-1:0] fi,
    output logic [REG_W-1:0] fj,
    output logic [REG_W-1:0] fk,
    output logic             uj,
    output logic             uk,
    output logic             rj,
    output logic             rk
);

    stage_e           stage_q, stage_d;
    logic [UID_W-1:0] qj_q, qk_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= ST_WRITTEN;
        end else begin
            stage_q <= stage_d;
        end
    end

    // Transitions
    always_comb begin
        stage_d = stage_q;
        unique case (stage_q)
            ST_WRITTEN:   if (issue_en)   stage_d = ST_ISSUED;
            ST_ISSUED:    if (rj && rk)   stage_d = ST_READ;
            ST_READ:      if (fu_done)    stage_d = ST_EXEC_DONE;
            ST_EXEC_DONE: if (wb_take)    stage_d = ST_WRITTEN;
        endcase
    end

    // Outputs
    always_comb begin
        busy   = (stage_q != ST_WRITTEN);
        rd_req = (stage_q == ST_ISSUED) && rj && rk;
        wb_req = (stage_q == ST_EXEC_DONE);
    end

    // Entry fields: loaded at issue, flags consumed at read, woken on broadcast
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op   <= '0;
            fi   <= '0;
            fj   <= '0;
            fk   <= '0;
            uj   <= 1'b0;
            uk   <= 1'b0;
            rj   <= 1'b0;
            rk   <= 1'b0;
            qj_q <= '0;
            qk_q <= '0;
        end else if (issue_en && stage_q == ST_WRITTEN) begin
            op   <= iss_op;
            fi   <= iss_dst;
            fj   <= iss_src1;
            fk   <= iss_src2;
            uj   <= iss_use1;
            uk   <= iss_use2;
            rj   <= !iss_wait1;
            rk   <= !iss_wait2;
            qj_q <= iss_q1;
            qk_q <= iss_q2;
        end else if (stage_q == ST_ISSUED) begin
            if (rj && rk) begin
                rj <= 1'b0;
                rk <= 1'b0;
            end else begin
                if (!rj && wb_valid && qj_q == wb_tag) rj <= 1'b1;
                if (!rk && wb_valid && qk_q == wb_tag) rk <= 1'b1;
            end
        end
    end

    AST_READ_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (!rj && !rk && stage_q == ST_READ)) else $error("read flags"); // R6

    AST_ISSUED_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_ISSUED) |=> (stage_q == ST_ISSUED || stage_q == ST_READ)) else $error("issued path"); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_EXEC_DONE && !wb_take) |=> (stage_q == ST_EXEC_DONE)) else $error("done hold"); // R8

    AST_DONE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_done && stage_q == ST_ISSUED) |=> (stage_q != ST_EXEC_DONE)) else $error("early done"); // R7

endmodule

// File: rtl/sb_result_status.sv
module sb_result_status #(
    parameter int N_REGS = 16,
    parameter int REG_W  = 4,
    parameter int UID_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] look1,
    input  logic [REG_W-1:0] look2,
    input  logic [REG_W-1:0] look_dst,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [UID_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    output logic             pend1,
    output logic [UID_W-1:0] own1,
    output logic             pend2,
    output logic [UID_W-1:0] own2,
    output logic             dst_pend
);

    logic [N_REGS-1:0]            pend;
    logic [N_REGS-1:0][UID_W-1:0] owner;

    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[r]  <= 1'b0;
                owner[r] <= '0;
            end else if (set_en && set_reg == REG_W'(r)) begin
                pend[r]  <= 1'b1;
                owner[r] <= set_tag;
            end else if (clr_en && clr_reg == REG_W'(r)) begin
                pend[r]  <= 1'b0;
            end
        end
    end

    always_comb begin
        pend1    = pend[look1];
        own1     = owner[look1];
        pend2    = pend[look2];
        own2     = owner[look2];
        dst_pend = pend[look_dst];
    end

    AST_DST_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (pend[$past(set_reg)] && owner[$past(set_reg)] == $past(set_tag))) else $error("dst record"); // R3

    AST_DST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_reg == clr_reg)) |=> !pend[$past(clr_reg)]) else $error("dst release"); // R12

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
    parameter int N_UNITS = 4,
    parameter int REG_W   = 4,
    parameter int UID_W   = 2
) (
    input  logic [N_UNITS-1:0]            wb_req,
    input  logic [N_UNITS-1:0]            busy,
    input  logic [N_UNITS-1:0][REG_W-1:0] fi,
    input  logic [N_UNITS-1:0][REG_W-1:0] fj,
    input  logic [N_UNITS-1:0][REG_W-1:0] fk,
    input  logic [N_UNITS-1:0]            uj,
    input  logic [N_UNITS-1:0]            uk,
    input  logic [N_UNITS-1:0]            rj,
    input  logic [N_UNITS-1:0]            rk,
    output logic [N_UNITS-1:0]            grant,
    output logic                          grant_valid,
    output logic [UID_W-1:0]              grant_idx
);

    logic [N_UNITS-1:0] war_blk;
    logic [N_UNITS-1:0] eligible;

    // WAR: another unit still owes a read of the old value of fi[u]
    for (genvar u = 0; u < N_UNITS; u++) begin : g_war
        always_comb begin
            war_blk[u] = 1'b0;
            for (int v = 0; v < N_UNITS; v++) begin
                if (v != u && busy[v]) begin
                    if (uj[v] && rj[v] && fj[v] == fi[u]) war_blk[u] = 1'b1;
                    if (uk[v] && rk[v] && fk[v] == fi[u]) war_blk[u] = 1'b1;
                end
            end
            eligible[u] = wb_req[u] && !war_blk[u];
        end
    end

    // Fixed priority, lowest index first
    always_comb begin
        grant       = '0;
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int u = N_UNITS - 1; u >= 0; u--) begin
            if (eligible[u]) begin
                grant       = '0;
                grant[u]    = 1'b1;
                grant_valid = 1'b1;
                grant_idx   = UID_W'(u);
            end
        end
    end

endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl #(
    parameter int N_UNITS = 4,
    parameter int N_REGS  = 16,
    parameter int OP_W    = 4,
    localparam int UID_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    localparam int REG_W  = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         iss_valid,
    input  logic [OP_W-1:0]              iss_op,
    input  logic [UID_W-1:0]             iss_unit,
    input  logic [REG_W-1:0]             iss_dst,
    input  logic [REG_W-1:0]             iss_src1,
    input  logic [REG_W-1:0]             iss_src2,
    input  logic                         iss_src1_imm,
    input  logic                         iss_src2_imm,
    input  logic [N_UNITS-1:0]           fu_done,
    output logic                         iss_stall,
    output logic [N_UNITS-1:0]           rd_grant,
    output logic [N_UNITS-1:0]           wb_grant,
    output logic [N_UNITS-1:0][OP_W-1:0] unit_op
);

    localparam logic [UID_W:0] UNIT_LIM = (UID_W + 1)'(N_UNITS);

    logic [N_UNITS-1:0]            busy, wb_req;
    logic [N_UNITS-1:0][REG_W-1:0] fi, fj, fk;
    logic [N_UNITS-1:0]            uj, uk, rj, rk;
    logic                          wb_valid;
    logic [UID_W-1:0]              wb_idx;
    logic                          pend1, pend2, dst_pend;
    logic [UID_W-1:0]              own1, own2;
    logic                          unit_ok, unit_busy, issue_fire;
    logic                          wait1, wait2;

    // Issue decision
    always_comb begin
        unit_ok    = ({1'b0, iss_unit} < UNIT_LIM);
        unit_busy  = unit_ok && busy[iss_unit];
        iss_stall  = iss_valid && (!unit_ok || unit_busy || dst_pend);
        issue_fire = iss_valid && !iss_stall;
        // a producer writing back in this cycle counts as already written
        wait1 = !iss_src1_imm && pend1 && !(wb_valid && own1 == wb_idx);
        wait2 = !iss_src2_imm && pend2 && !(wb_valid && own2 == wb_idx);
    end

    sb_result_status #(
        .N_REGS (N_REGS),
        .REG_W  (REG_W),
        .UID_W  (UID_W)
    ) u_rstat (
        .clk      (clk),
        .rst_n    (rst_n),
        .look1    (iss_src1),
        .look2    (iss_src2),
        .look_dst (iss_dst),
        .set_en   (issue_fire),
        .set_reg  (iss_dst),
        .set_tag  (iss_unit),
        .clr_en   (wb_valid),
        .clr_reg  (fi[wb_idx]),
        .pend1    (pend1),
        .own1     (own1),
        .pend2    (pend2),
        .own2     (own2),
        .dst_pend (dst_pend)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        sb_unit_entry #(
            .OP_W  (OP_W),
            .REG_W (REG_W),
            .UID_W (UID_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue_en  (issue_fire && iss_unit == UID_W'(u)),
            .iss_op    (iss_op),
            .iss_dst   (iss_dst),
            .iss_src1  (iss_src1),
            .iss_src2  (iss_src2),
            .iss_use1  (!iss_src1_imm),
            .iss_use2  (!iss_src2_imm),
            .iss_wait1 (wait1),
            .iss_wait2 (wait2),
            .iss_q1    (own1),
            .iss_q2    (own2),
            .wb_valid  (wb_valid),
            .wb_tag    (wb_idx),
            .wb_take   (wb_grant[u]),
            .fu_done   (fu_done[u]),
            .busy      (busy[u]),
            .rd_req    (rd_grant[u]),
            .wb_req    (wb_req[u]),
            .op        (unit_op[u]),
            .fi        (fi[u]),
            .fj        (fj[u]),
            .fk        (fk[u]),
            .uj        (uj[u]),
            .uk        (uk[u]),
            .rj        (rj[u]),
            .rk        (rk[u])
        );

        AST_WB_FREES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |=> !busy[u]) else $error("unit not freed"); // R12
    end

    sb_wb_arbiter #(
        .N_UNITS (N_UNITS),
        .REG_W   (REG_W),
        .UID_W   (UID_W)
    ) u_arb (
        .wb_req      (wb_req),
        .busy        (busy),
        .fi          (fi),
        .fj          (fj),
        .fk          (fk),
        .uj          (uj),
        .uk          (uk),
        .rj          (rj),
        .rk          (rk),
        .grant       (wb_grant),
        .grant_valid (wb_valid),
        .grant_idx   (wb_idx)
    );

    AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant)) else $error("multiple write-backs"); // R9

    AST_STALL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && unit_ok && busy[iss_unit]) |-> iss_stall) else $error("busy unit issued"); // R2

    AST_ISSUE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> busy[$past(iss_unit)]) else $error("issue lost"); // R4

endmodule

// File: tb/sb_hazard_ctrl_tb.sv
module sb_hazard_ctrl_tb;

    localparam int NU = 4;
    localparam int VW = 34;
    localparam int NV = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             iss_valid = 1'b0;
    logic [3:0]       iss_op = '0;
    logic [1:0]       iss_unit = '0;
    logic [3:0]       iss_dst = '0;
    logic [3:0]       iss_src1 = '0;
    logic [3:0]       iss_src2 = '0;
    logic             iss_src1_imm = 1'b0;
    logic             iss_src2_imm = 1'b0;
    logic [NU-1:0]    fu_done = '0;
    logic             iss_stall;
    logic [NU-1:0]    rd_grant;
    logic [NU-1:0]    wb_grant;
    logic [NU-1:0][3:0] unit_op;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sb_hazard_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .iss_valid    (iss_valid),
        .iss_op       (iss_op),
        .iss_unit     (iss_unit),
        .iss_dst      (iss_dst),
        .iss_src1     (iss_src1),
        .iss_src2     (iss_src2),
        .iss_src1_imm (iss_src1_imm),
        .iss_src2_imm (iss_src2_imm),
        .fu_done      (fu_done),
        .iss_stall    (iss_stall),
        .rd_grant     (rd_grant),
        .wb_grant     (wb_grant),
        .unit_op      (unit_op)
    );

    // {valid, unit, dst, src1, src2, imm1, imm2, done, exp_stall, exp_rd, exp_wb, req}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0000,1'b0,4'b0000,4'b0000,4'd1 },  // R1 idle
        {1'b1,2'd0,4'd1, 4'd2,4'd3,1'b0,1'b0,4'b0000,1'b0,4'b0000,4'b0000,4'd5 },  // R5 U0 r1<-r2,r3
        {1'b1,2'd1,4'd4, 4'd1,4'd5,1'b0,1'b0,4'b0000,1'b0,4'b0001,4'b0000,4'd6 },  // R6 U1 waits on r1
        {1'b1,2'd0,4'd6, 4'd2,4'd3,1'b0,1'b0,4'b0000,1'b1,4'b0000,4'b0000,4'd2 },  // R2 U0 busy
        {1'b1,2'd2,4'd1, 4'd2,4'd3,1'b0,1'b0,4'b0010,1'b1,4'b0000,4'b0000,4'd3 },  // R3 r1 pending; stray done
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0001,1'b0,4'b0000,4'b0000,4'd5 },  // R5 U1 still waiting
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0000,1'b0,4'b0000,4'b0001,4'd8 },  // R8 waiting reader no hold
        {1'b1,2'd0,4'd1, 4'd4,4'd7,1'b0,1'b0,4'b0000,1'b0,4'b0010,4'b0000,4'd10},  // R10 woken U1
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0010,1'b0,4'b0000,4'b0000,4'd7 },  // R7 done in read
        {1'b1,2'd2,4'd13,4'd4,4'd5,1'b0,1'b0,4'b0000,1'b0,4'b0000,4'b0010,4'd11},  // R11 issue with wb
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0000,1'b0,4'b0101,4'b0000,4'd11},  // R11 both read
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0101,1'b0,4'b0000,4'b0000,4'd6 },  // R6 single cycle
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0000,1'b0,4'b0000,4'b0001,4'd9 },  // R9 lowest first
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0000,1'b0,4'b0000,4'b0100,4'd9 },  // R9 then U2
        {1'b1,2'd1,4'd8, 4'd0,4'd0,1'b1,1'b1,4'b0000,1'b0,4'b0000,4'b0000,4'd12},  // R12 freed unit
        {1'b1,2'd0,4'd2, 4'd6,4'd8,1'b0,1'b0,4'b0000,1'b0,4'b0010,4'b0000,4'd5 },  // R5 reader of r6
        {1'b1,2'd2,4'd6, 4'd0,4'd0,1'b1,1'b1,4'b0000,1'b0,4'b0000,4'b0000,4'd4 },  // R4 r6/U2 accepted
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0010,1'b0,4'b0100,4'b0000,4'd5 },  // R5
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0100,1'b0,4'b0000,4'b0010,4'd10},  // R10 wakes U0
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0000,1'b0,4'b0001,4'b0000,4'd8 },  // R8 U2 held
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0000,1'b0,4'b0000,4'b0100,4'd8 },  // R8 released
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0001,1'b0,4'b0000,4'b0000,4'd7 },  // R7
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0000,1'b0,4'b0000,4'b0001,4'd9 },  // R9
        {1'b0,2'd0,4'd0, 4'd0,4'd0,1'b0,1'b0,4'b0000,1'b0,4'b0000,4'b0000,4'd1 }   // R1 drained
    };

    task automatic check(input int req, input string what, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] u, input logic [3:0] d,
                         input logic [3:0] s1, input logic [3:0] s2,
                         input logic i1, input logic i2, input logic [3:0] dn);
        iss_valid    = v;
        iss_unit     = u;
        iss_dst      = d;
        iss_src1     = s1;
        iss_src2     = s2;
        iss_src1_imm = i1;
        iss_src2_imm = i2;
        iss_op       = {2'b10, u};
        fu_done      = dn;
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] r;
            r = VEC[i];
            @(negedge clk);
            drive(r[33], r[32:31], r[30:27], r[26:23], r[22:19], r[18], r[17], r[16:13]);
            #1;
            check(int'(r[3:0]), "stall",    {3'b0, iss_stall}, {3'b0, r[12]});
            check(int'(r[3:0]), "rd_grant", rd_grant, r[11:8]);
            check(int'(r[3:0]), "wb_grant", wb_grant, r[7:4]);
        end

        // R5: both sources bypassed -> read grant in the following cycle
        @(negedge clk);
        drive(1'b1, 2'd3, 4'd3, 4'd0, 4'd0, 1'b1, 1'b1, 4'b0000);
        #1 check(5, "stall", {3'b0, iss_stall}, 4'b0000);
        @(negedge clk);
        drive(1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'b0000);
        #1 check(5, "rd_grant", rd_grant, 4'b1000);
        check(5, "unit_op", unit_op[3], 4'b1011);

        // R1: reset mid-flight clears grants and frees unit and register
        @(negedge clk);
        rst_n = 1'b0;
        #1 check(1, "rd_grant", rd_grant, 4'b0000);
        check(1, "wb_grant", wb_grant, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b1, 2'd3, 4'd3, 4'd5, 4'd6, 1'b0, 1'b0, 4'b0000);
        #1 check(1, "stall", {3'b0, iss_stall}, 4'b0000);
        @(negedge clk);
        drive(1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'b0000);
        #1 check(1, "rd_grant", rd_grant, 4'b1000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule